// File: doc/BRIEF.md
# Keyboard Scancode Receiver with Queue and Undo

This block listens to the two open-collector lines of a keyboard port (clock and data) in one direction only. It never drives them. Both lines are resynchronised to the system clock and debounced. Each falling edge of the filtered keyboard clock shifts one bit into a frame assembler. A complete eleven-bit frame is accepted only when its start, parity and stop bits are all correct. An accepted byte is pushed into a sixteen-entry register queue.

A reader pops the queue on every cycle in which the queue holds anything. Each popped byte is written into a history ring and becomes the displayed scancode. The display has two parts: the raw byte, and a four-bit digit code. The digit code is 0 to 9 for the number-row keys and an error symbol for every other scancode.

An undo control lets the user walk back through earlier key presses, one step per press of the control. The walk stops at the oldest entry the history still holds. Any newly arriving scancode returns the display to the most recent key.

Top module: `kbd_scan_rx`

## Requirements
- R1: A frame is eleven bits, each sampled on a falling edge of the debounced keyboard clock, in this order: a start bit of 0, eight data bits least significant first, a parity bit, and a stop bit of 1. A valid frame's data byte appears on `code_o` as the newest scancode.
- R2: A frame whose data bits and parity bit together hold an even number of ones is discarded. The display keeps its previous value.
- R3: A frame whose stop bit is 0 is discarded. The display keeps its previous value.
- R4: If a partial frame sees no keyboard clock edge for `TIMEOUT_CYCLES` system cycles, it is abandoned. The next frame is then received correctly from its start bit.
- R5: Accepted bytes enter a queue of `QUEUE_DEPTH` (16) entries. The queue never reports more than its depth. The reader pops it on every cycle in which it is not empty.
- R6: For a displayed scancode, `digit_o` gives these values: 0x45→0, 0x16→1, 0x1E→2, 0x26→3, 0x25→4, 0x2E→5, 0x36→6, 0x3D→7, 0x3E→8, 0x46→9.
- R7: Every other displayed scancode gives `digit_o` = 0xE.
- R8: Each rising edge of `undo_i` moves the display one entry back in the history, to the key pressed before the one shown.
- R9: Undo saturates at the oldest retained entry. The history retains the last `HIST_DEPTH` (16) scancodes, and further undo edges leave the display unchanged.
- R10: A newly popped scancode resets the undo position, so the display shows that newest scancode.
- R11: After reset, and until the first scancode, `have_code_o` = 0, `code_o` = 0x00 and `digit_o` = 0xF.
- R12: A level change on either keyboard line that lasts fewer than `DEB_CYCLES` system cycles is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kb_clk_i | input | 1 | Keyboard clock line (asynchronous) |
| kb_dat_i | input | 1 | Keyboard data line (asynchronous) |
| undo_i | input | 1 | Step-back control, acted on at its rising edge |
| code_o | output | 8 | Displayed scancode byte |
| digit_o | output | 4 | 0 to 9 for number keys, 0xE for other keys, 0xF when empty |
| have_code_o | output | 1 | At least one scancode has been received |

## Verification
The bench sends frames with bad parity and with a zero stop bit. A design that skipped either test would show the corrupt byte on the display. It also sends a five-bit fragment followed by a long gap. Without the idle timeout, the next frame would be misaligned and lost. A three-cycle glitch on the keyboard clock just before a frame checks the debouncer: a receiver that counted the glitch as a bit would drop the real frame. Finally, the bench sends more than sixteen keys and issues more undo edges than the history holds. A pointer that wrapped instead of saturating would jump back to the newest key, and a missing reset of the undo position would hide a new press.

// File: rtl/kbd_scan_pkg.sv
package kbd_scan_pkg;
  localparam logic [3:0] DIGIT_ERR  = 4'hE;
  localparam logic [3:0] DIGIT_NONE = 4'hF;

  // true when data plus parity hold an odd number of ones
  function automatic logic odd_parity_ok(input logic [7:0] data, input logic par);
    return ^{data, par};
  endfunction

  // number-row scancode to decimal digit, error symbol otherwise
  function automatic logic [3:0] scan_to_digit(input logic [7:0] sc);
    case (sc)
      8'h45: return 4'd0;
      8'h16: return 4'd1;
      8'h1E: return 4'd2;
      8'h26: return 4'd3;
      8'h25: return 4'd4;
      8'h2E: return 4'd5;
      8'h36: return 4'd6;
      8'h3D: return 4'd7;
      8'h3E: return 4'd8;
      8'h46: return 4'd9;
      default: return DIGIT_ERR;
    endcase
  endfunction
endpackage

// File: rtl/kbd_line_filter.sv
module kbd_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYCLES  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] raw_i,     // [0] keyboard clock, [1] keyboard data
  output logic [1:0] filt_o,
  output logic       clk_fall_o
);
  localparam int CW = $clog2(DEB_CYCLES + 1);

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [SYNC_STAGES-1:0] sy;
    logic [CW-1:0]          cnt;
    logic                   f;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sy  <= '1;
        cnt <= '0;
        f   <= 1'b1;
      end else begin
        sy <= {sy[SYNC_STAGES-2:0], raw_i[g]};
        if (sy[SYNC_STAGES-1] != f) begin
          if (cnt == CW'(DEB_CYCLES - 1)) begin
            f   <= sy[SYNC_STAGES-1];
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else begin
          cnt <= '0;
        end
      end
    end
    assign filt_o[g] = f;
  end

  logic clk_prev;
  always_ff @(posedge clk) begin
    if (!rst_n) clk_prev <= 1'b1;
    else        clk_prev <= filt_o[0];
  end
  assign clk_fall_o = clk_prev & ~filt_o[0];
endmodule

// File: rtl/kbd_frame_rx.sv
module kbd_frame_rx
  import kbd_scan_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fall_i,
  input  logic       dat_i,
  output logic       byte_vld_o,
  output logic [7:0] byte_o,
  output logic       frame_drop_o
);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);

  logic [9:0]    sh;       // after ten shifts: [0] start, [8:1] data, [9] parity
  logic [3:0]    nbits;
  logic [TW-1:0] idle;
  logic          frame_ok;

  assign frame_ok = !sh[0] && dat_i && odd_parity_ok(sh[8:1], sh[9]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh           <= '0;
      nbits        <= '0;
      idle         <= '0;
      byte_vld_o   <= 1'b0;
      byte_o       <= '0;
      frame_drop_o <= 1'b0;
    end else begin
      byte_vld_o   <= 1'b0;
      frame_drop_o <= 1'b0;
      if (fall_i) begin
        idle <= '0;
        if (nbits == 4'd10) begin
          nbits <= '0;
          if (frame_ok) begin
            byte_vld_o <= 1'b1;
            byte_o     <= sh[8:1];
          end else begin
            frame_drop_o <= 1'b1;
          end
        end else begin
          sh    <= {dat_i, sh[9:1]};
          nbits <= nbits + 1'b1;
        end
      end else if (nbits != 4'd0) begin
        if (idle == TW'(TIMEOUT_CYCLES - 1)) begin
          nbits <= '0;
          idle  <= '0;
        end else begin
          idle <= idle + 1'b1;
        end
      end else begin
        idle <= '0;
      end
    end
  end
endmodule

// File: rtl/kbd_scan_fifo.sv
module kbd_scan_fifo #(
  parameter int DEPTH = 16,   // power of two
  parameter int W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_i,
  input  logic [W-1:0]               din_i,
  input  logic                       pop_i,
  output logic [W-1:0]               dout_o,
  output logic [$clog2(DEPTH):0]     count_o,
  output logic                       empty_o,
  output logic                       full_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign empty_o = (count_o == '0);
  assign full_o  = (count_o == (AW+1)'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign dout_o  = mem[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      count_o <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (do_push) begin
        mem[wp] <= din_i;
        wp      <= wp + 1'b1;
      end
      if (do_pop) rp <= rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count_o <= count_o + 1'b1;
        2'b01:   count_o <= count_o - 1'b1;
        default: count_o <= count_o;
      endcase
    end
  end
endmodule

// File: rtl/kbd_scan_rx.sv
module kbd_scan_rx
  import kbd_scan_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int DEB_CYCLES     = 8,
  parameter int TIMEOUT_CYCLES = 5000,
  parameter int QUEUE_DEPTH    = 16,
  parameter int HIST_DEPTH     = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kb_clk_i,
  input  logic       kb_dat_i,
  input  logic       undo_i,
  output logic [7:0] code_o,
  output logic [3:0] digit_o,
  output logic       have_code_o
);
  localparam int QCW = $clog2(QUEUE_DEPTH) + 1;
  localparam int HW  = $clog2(HIST_DEPTH);

  logic [1:0]     filt;
  logic           kb_fall;
  logic           byte_vld, frame_drop;
  logic [7:0]     rx_byte, q_head;
  logic [QCW-1:0] q_count;
  logic           q_empty, q_full;

  kbd_line_filter #(.SYNC_STAGES(SYNC_STAGES), .DEB_CYCLES(DEB_CYCLES)) u_filt (
    .clk(clk), .rst_n(rst_n), .raw_i({kb_dat_i, kb_clk_i}),
    .filt_o(filt), .clk_fall_o(kb_fall));

  kbd_frame_rx #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_frame (
    .clk(clk), .rst_n(rst_n), .fall_i(kb_fall), .dat_i(filt[1]),
    .byte_vld_o(byte_vld), .byte_o(rx_byte), .frame_drop_o(frame_drop));

  // named events for the checker
  logic pop_evt, undo_evt, at_oldest;

  kbd_scan_fifo #(.DEPTH(QUEUE_DEPTH), .W(8)) u_q (
    .clk(clk), .rst_n(rst_n), .push_i(byte_vld), .din_i(rx_byte),
    .pop_i(pop_evt), .dout_o(q_head), .count_o(q_count),
    .empty_o(q_empty), .full_o(q_full));

  // reader: drains whenever the queue holds data
  assign pop_evt = !q_empty;

  logic [7:0]    hist [HIST_DEPTH];
  logic [HW-1:0] hwr, back, show_idx;
  logic [HW:0]   hcount;
  logic          undo_q;

  assign undo_evt  = undo_i && !undo_q;
  assign at_oldest = (hcount == '0) || ({1'b0, back} == hcount - 1'b1);
  assign show_idx  = hwr - 1'b1 - back;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hwr    <= '0;
      hcount <= '0;
      back   <= '0;
      undo_q <= 1'b0;
      for (int i = 0; i < HIST_DEPTH; i++) hist[i] <= '0;
    end else begin
      undo_q <= undo_i;
      if (pop_evt) begin
        hist[hwr] <= q_head;
        hwr       <= hwr + 1'b1;
        back      <= '0;
        if (hcount != (HW+1)'(HIST_DEPTH)) hcount <= hcount + 1'b1;
      end else if (undo_evt && !at_oldest) begin
        back <= back + 1'b1;
      end
    end
  end

  assign have_code_o = (hcount != '0);
  assign code_o      = have_code_o ? hist[show_idx] : 8'h00;
  assign digit_o     = have_code_o ? scan_to_digit(code_o) : DIGIT_NONE;
endmodule

// File: rtl/kbd_scan_rx_chk.sv
module kbd_scan_rx_chk #(
  parameter int HW  = 4,
  parameter int QCW = 5,
  parameter int QUEUE_DEPTH = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           pop_evt,
  input logic           undo_evt,
  input logic           at_oldest,
  input logic [7:0]     q_head,
  input logic [QCW-1:0] q_count,
  input logic [HW-1:0]  back,
  input logic [7:0]     code_o,
  input logic [3:0]     digit_o,
  input logic           have_code_o
);
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= QCW'(QUEUE_DEPTH));

  assert_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (q_count != '0) |-> pop_evt);

  assert_newest_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pop_evt |=> (code_o == $past(q_head)) && have_code_o);

  assert_undo_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (undo_evt && !pop_evt && !at_oldest) |=> back == $past(back) + 1'b1);

  assert_undo_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (undo_evt && !pop_evt && at_oldest) |=> $stable(code_o));

  assert_digit_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    have_code_o |-> (digit_o <= 4'd9 || digit_o == 4'hE));

  assert_empty_state_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !have_code_o |-> (code_o == 8'h00 && digit_o == 4'hF));
endmodule

bind kbd_scan_rx kbd_scan_rx_chk #(.HW(HW), .QCW(QCW), .QUEUE_DEPTH(QUEUE_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .pop_evt(pop_evt), .undo_evt(undo_evt),
  .at_oldest(at_oldest), .q_head(q_head), .q_count(q_count), .back(back),
  .code_o(code_o), .digit_o(digit_o), .have_code_o(have_code_o));

// File: tb/tb_kbd_scan_rx.sv
module tb_kbd_scan_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic kb_clk = 1'b1, kb_dat = 1'b1, undo = 1'b0;
  logic [7:0] code;
  logic [3:0] digit;
  logic have;

  int checks = 0, fails = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  // reference model
  int hist[$];
  int back = 0;

  always #10 clk = ~clk;   // 50 MHz

  kbd_scan_rx dut (
    .clk(clk), .rst_n(rst_n), .kb_clk_i(kb_clk), .kb_dat_i(kb_dat),
    .undo_i(undo), .code_o(code), .digit_o(digit), .have_code_o(have));

  function automatic int ref_digit(int sc);
    int keys[10] = '{'h45, 'h16, 'h1E, 'h26, 'h25, 'h2E, 'h36, 'h3D, 'h3E, 'h46};
    foreach (keys[i]) if (keys[i] == sc) return i;
    return 14;
  endfunction

  function automatic int exp_code();
    if (hist.size() == 0) return 0;
    return hist[hist.size() - 1 - back];
  endfunction

  function automatic int exp_digit();
    if (hist.size() == 0) return 15;
    return ref_digit(exp_code());
  endfunction

  task automatic chk(input string tag);
    checks++;
    if (code !== 8'(exp_code()) || digit !== 4'(exp_digit()) || have !== (hist.size() != 0)) begin
      fails++;
      $display("FAIL %s code=%h/%h digit=%h/%h have=%b/%b", tag, code, 8'(exp_code()),
               digit, 4'(exp_digit()), have, hist.size() != 0);
    end
  endtask

  // per-clock comparison while the model is settled
  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      if (code !== 8'(exp_code()) || digit !== 4'(exp_digit())) begin
        fails++;
        $display("FAIL R1 per-clock code=%h/%h digit=%h/%h", code, 8'(exp_code()),
                 digit, 4'(exp_digit()));
      end
    end
  end

  task automatic send_bit(input logic b);
    @(negedge clk) kb_dat = b;
    repeat (20) @(negedge clk);
    kb_clk = 1'b0;
    repeat (40) @(negedge clk);
    kb_clk = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    logic p;
    cmp_en = 1'b0;
    p = ~(^d) ^ bad_par;
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    send_bit(p);
    send_bit(~bad_stop);
    kb_dat = 1'b1;
    repeat (60) @(negedge clk);
    if (!bad_par && !bad_stop) begin
      hist.push_back(int'(d));
      if (hist.size() > 16) void'(hist.pop_front());
      back = 0;
    end
    cmp_en = 1'b1;
  endtask

  task automatic pulse_undo();
    cmp_en = 1'b0;
    @(negedge clk) undo = 1'b1;
    @(negedge clk) undo = 1'b0;
    repeat (3) @(negedge clk);
    if (back < hist.size() - 1) back++;
    cmp_en = 1'b1;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    cmp_en = 1'b1;
    chk("R11 reset state");

    send_frame(8'h16, 0, 0); chk("R1 key 1 byte / R6 digit 1");
    send_frame(8'h45, 0, 0); chk("R6 digit 0");
    send_frame(8'h46, 0, 0); chk("R6 digit 9");
    send_frame(8'h1C, 0, 0); chk("R7 non-number key");
    send_frame(8'h3D, 0, 0); chk("R1 R6 digit 7");
    send_frame(8'hA5, 1, 0); chk("R2 bad parity dropped");
    send_frame(8'h5A, 0, 1); chk("R3 bad stop dropped");

    // R4: fragment then long idle gap
    cmp_en = 1'b0;
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    repeat (6000) @(negedge clk);
    cmp_en = 1'b1;
    send_frame(8'h2E, 0, 0); chk("R4 timeout resync");

    // R12: short glitch on keyboard clock just before a frame
    cmp_en = 1'b0;
    kb_clk = 1'b0; repeat (3) @(negedge clk); kb_clk = 1'b1;
    repeat (30) @(negedge clk);
    cmp_en = 1'b1;
    send_frame(8'h26, 0, 0); chk("R12 glitch ignored");

    pulse_undo(); chk("R8 undo one step");
    pulse_undo(); chk("R8 undo second step");
    send_frame(8'h3E, 0, 0); chk("R10 new key returns to newest");

    // R5/R9: overfill history, then undo past the oldest entry
    for (int i = 0; i < 17; i++) send_frame(8'(8'h60 + i), 0, 0);
    chk("R5 queue drained to newest");
    for (int i = 0; i < 20; i++) pulse_undo();
    chk("R9 undo saturates at oldest");
    checks++;
    if (code !== 8'h60 + 8'd1) begin
      fails++;
      $display("FAIL R9 oldest code=%h expected=%h", code, 8'h61);
    end

    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule